// File: doc/BRIEF.md
# FSK Proximity Tag Waveform Generator

This block produces the coil-modulation bit stream of a low-frequency FSK proximity tag carrying a 44-bit identifier. Each bit of the ID becomes two Manchester half-bits. Each half-bit is a burst of one of two sub-carrier patterns: one with a period of eight carrier cycles and one with a period of ten. The frame starts with a start marker that breaks the Manchester rules on purpose. An extra short-period burst comes before each nibble of the ID. The frame repeats without a gap for as long as the block is enabled.

The sample clock is a one-cycle strobe that marks each rising edge of the carrier. On every strobe the block presents the next sample on `modOut` and holds it until the next strobe. A 1 opens the coil and a 0 shorts it. The frame is produced on the fly from counters, with no stored sample table. A new ID is taken only at a frame boundary, so a frame on the air never mixes two IDs.

Top module: `fskTagGen`

## Requirements
- R1: While reset is asserted, `modOut` and `frameStart` are both 0.
- R2: A short-period group (code 0) is the 8-sample pattern 1,1,0,0,0,0,0,0 sent 6 times, giving 48 samples.
- R3: A long-period group (code 1) is the 10-sample pattern 1,1,1,0,0,0,0,0,0,0 sent 5 times, giving 50 samples.
- R4: Every frame opens with eight marker groups with the codes 0,0,0,1,1,1,0,1 in that order.
- R5: After the marker, the ID is sent from bit 43 down to bit 0. A 1 bit is a long group followed by a short group. A 0 bit is a short group followed by a long group.
- R6: One extra short group comes before bits 43, 39, 35, …, 3, which is before each run of four ID bits.
- R7: A frame is 5232 samples long, and the next frame starts on the strobe after the last sample, with no gap.
- R8: Each strobe taken while enabled advances the waveform by exactly one sample. `modOut` keeps its value on every clock without a strobe.
- R9: `frameStart` is high for exactly one clock, in the cycle in which the first marker sample appears on `modOut`. It is low at all other times.
- R10: `tagId` is sampled only on the strobe that emits the first sample of a frame. Changing it at any other time has no effect on the frame in progress.
- R11: While `enable` is low, `modOut` and `frameStart` are 0 and strobes are ignored. The first strobe after `enable` rises emits the first marker sample, with `frameStart` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the generator; low clears it to the frame start |
| carrierTick | input | 1 | One-clock strobe per carrier rising edge |
| tagId | input | 44 | Identifier to transmit |
| modOut | output | 1 | Coil modulation sample (1 open, 0 short) |
| frameStart | output | 1 | One-clock pulse with the first sample of each frame |

## Verification
The bench computes every sample of each frame by walking the group sequence arithmetically, and compares it over complete frames for three IDs. An all-zeros ID puts only the "short then long" ordering in each bit. An all-ones ID puts only the "long then short" ordering. A mixed ID separates a correct bit order from a reversed or shifted one, and shows whether the filler falls at the nibble edges. The ID is changed partway through a frame, which shows whether it is latched only at the boundary. Idle clocks are placed between strobes to check that samples hold. A disable in the middle of a frame checks that output is cleared and that the restart lands at the marker.

// File: rtl/fskPkg.sv
package fskPkg;

  // Strobes from the sequencer to the datapath, one set per clock
  typedef struct packed {
    logic clearOut;   // generator idle: force the coil to short
    logic emit;       // present sampleVal on the output this clock
    logic sampleVal;  // waveform value for the current position
    logic frameFirst; // current position is sample 0 of the frame
    logic latchId;    // capture a fresh identifier
    logic shiftId;    // a data bit has been fully sent
  } seqStrobes_t;

  function automatic int frameLen(int idBits, int bitsPerNib, int sofGroups,
                                  int sofLong, int shortLen, int longLen);
    return (sofGroups - sofLong) * shortLen + sofLong * longLen
         + (idBits / bitsPerNib) * shortLen + idBits * (shortLen + longLen);
  endfunction

endpackage

// File: rtl/fskSequencer.sv
module fskSequencer
  import fskPkg::*;
#(
  parameter int ID_BITS      = 44,
  parameter int BITS_PER_NIB = 4,
  parameter int SHORT_PER    = 8,
  parameter int SHORT_HIGH   = 2,
  parameter int SHORT_REPS   = 6,
  parameter int LONG_PER     = 10,
  parameter int LONG_HIGH    = 3,
  parameter int LONG_REPS    = 5,
  parameter int SOF_GROUPS   = 8,
  parameter logic [SOF_GROUPS-1:0] SOF_KINDS = 8'hB8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        carrierTick,
  input  logic        idMsb,
  output seqStrobes_t strobes
);
  localparam int PH_MAX  = (SHORT_PER > LONG_PER) ? SHORT_PER : LONG_PER;
  localparam int PH_W    = $clog2(PH_MAX);
  localparam int REP_MAX = (SHORT_REPS > LONG_REPS) ? SHORT_REPS : LONG_REPS;
  localparam int REP_W   = $clog2(REP_MAX);
  localparam int SOF_W   = $clog2(SOF_GROUPS);
  localparam int NIBBLES = ID_BITS / BITS_PER_NIB;
  localparam int NIB_W   = $clog2(NIBBLES);
  localparam int SLOTS   = 2 * BITS_PER_NIB + 1; // filler + two halves per bit
  localparam int SLOT_W  = $clog2(SLOTS);

  logic [PH_W-1:0]   phase;
  logic [REP_W-1:0]  rep;
  logic              inSof;
  logic [SOF_W-1:0]  sofIdx;
  logic [SLOT_W-1:0] slot;
  logic [NIB_W-1:0]  nib;

  logic kindLong, lastPhase, lastRep, groupEnd, atFrameStart, step, sampleVal;

  // Group kind at the current position (R4, R5, R6)
  always_comb begin
    if (inSof)            kindLong = SOF_KINDS[sofIdx];
    else if (slot == '0)  kindLong = 1'b0;
    else if (slot[0])     kindLong = idMsb;   // first half carries the bit
    else                  kindLong = ~idMsb;  // second half its complement
  end

  // Sub-pattern shape (R2, R3)
  always_comb begin
    if (kindLong) begin
      lastPhase = (phase == PH_W'(LONG_PER - 1));
      lastRep   = (rep == REP_W'(LONG_REPS - 1));
      sampleVal = (phase < PH_W'(LONG_HIGH));
    end else begin
      lastPhase = (phase == PH_W'(SHORT_PER - 1));
      lastRep   = (rep == REP_W'(SHORT_REPS - 1));
      sampleVal = (phase < PH_W'(SHORT_HIGH));
    end
  end

  assign groupEnd     = lastPhase && lastRep;
  assign step         = enable && carrierTick;
  assign atFrameStart = inSof && (sofIdx == '0) && (phase == '0) && (rep == '0);

  always_comb begin
    strobes            = '0;
    strobes.clearOut   = ~enable;
    strobes.emit       = step;
    strobes.sampleVal  = sampleVal;
    strobes.frameFirst = step && atFrameStart;
    strobes.latchId    = step && atFrameStart;
    strobes.shiftId    = step && groupEnd && !inSof && (slot != '0) && !slot[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      phase  <= '0;
      rep    <= '0;
      inSof  <= 1'b1;
      sofIdx <= '0;
      slot   <= '0;
      nib    <= '0;
    end else if (carrierTick) begin
      if (lastPhase) begin
        phase <= '0;
        rep   <= lastRep ? '0 : rep + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
      if (groupEnd) begin
        if (inSof) begin
          if (sofIdx == SOF_W'(SOF_GROUPS - 1)) begin
            inSof <= 1'b0;
            slot  <= '0;
            nib   <= '0;
          end else begin
            sofIdx <= sofIdx + 1'b1;
          end
        end else if (slot == SLOT_W'(SLOTS - 1)) begin
          slot <= '0;
          if (nib == NIB_W'(NIBBLES - 1)) begin
            nib    <= '0;
            inSof  <= 1'b1;      // wrap to the marker (R7)
            sofIdx <= '0;
          end else begin
            nib <= nib + 1'b1;
          end
        end else begin
          slot <= slot + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fskDatapath.sv
module fskDatapath
  import fskPkg::*;
#(
  parameter int ID_BITS = 44
) (
  input  logic               clk,
  input  logic               rst_n,
  input  seqStrobes_t        strobes,
  input  logic [ID_BITS-1:0] tagId,
  output logic               idMsb,
  output logic               modOut,
  output logic               frameStart
);
  logic [ID_BITS-1:0] idReg;

  assign idMsb = idReg[ID_BITS-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idReg      <= '0;
      modOut     <= 1'b0;
      frameStart <= 1'b0;
    end else begin
      frameStart <= strobes.frameFirst;                   // R9
      if (strobes.clearOut)  modOut <= 1'b0;               // R11
      else if (strobes.emit) modOut <= strobes.sampleVal;  // R8
      if (strobes.latchId)       idReg <= tagId;           // R10
      else if (strobes.shiftId)  idReg <= {idReg[ID_BITS-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/fskTagGen.sv
module fskTagGen
  import fskPkg::*;
#(
  parameter int ID_BITS      = 44,
  parameter int BITS_PER_NIB = 4,
  parameter int SHORT_PER    = 8,
  parameter int SHORT_HIGH   = 2,
  parameter int SHORT_REPS   = 6,
  parameter int LONG_PER     = 10,
  parameter int LONG_HIGH    = 3,
  parameter int LONG_REPS    = 5,
  parameter int SOF_GROUPS   = 8,
  parameter logic [SOF_GROUPS-1:0] SOF_KINDS = 8'hB8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               carrierTick,
  input  logic [ID_BITS-1:0] tagId,
  output logic               modOut,
  output logic               frameStart
);
  seqStrobes_t strobes;
  logic        idMsb;

  fskSequencer #(
    .ID_BITS(ID_BITS), .BITS_PER_NIB(BITS_PER_NIB),
    .SHORT_PER(SHORT_PER), .SHORT_HIGH(SHORT_HIGH), .SHORT_REPS(SHORT_REPS),
    .LONG_PER(LONG_PER), .LONG_HIGH(LONG_HIGH), .LONG_REPS(LONG_REPS),
    .SOF_GROUPS(SOF_GROUPS), .SOF_KINDS(SOF_KINDS)
  ) seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .carrierTick(carrierTick),
    .idMsb(idMsb), .strobes(strobes)
  );

  fskDatapath #(.ID_BITS(ID_BITS)) dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .tagId(tagId),
    .idMsb(idMsb), .modOut(modOut), .frameStart(frameStart)
  );

endmodule

// File: rtl/fskTagGenChecker.sv
module fskTagGenChecker #(
  parameter int ID_BITS      = 44,
  parameter int BITS_PER_NIB = 4,
  parameter int SHORT_PER    = 8,
  parameter int SHORT_REPS   = 6,
  parameter int LONG_PER     = 10,
  parameter int LONG_REPS    = 5,
  parameter int SOF_GROUPS   = 8,
  parameter logic [SOF_GROUPS-1:0] SOF_KINDS = 8'hB8
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic carrierTick,
  input logic modOut,
  input logic frameStart
);
  localparam int FRAME_LEN = fskPkg::frameLen(ID_BITS, BITS_PER_NIB, SOF_GROUPS,
                               $countones(SOF_KINDS), SHORT_PER * SHORT_REPS,
                               LONG_PER * LONG_REPS);
  localparam int CNT_W = $clog2(FRAME_LEN + 2);

  logic [CNT_W-1:0] tickCnt;
  logic             seenStart;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      tickCnt   <= '0;
      seenStart <= 1'b0;
    end else if (frameStart) begin
      tickCnt   <= carrierTick ? CNT_W'(1) : '0;
      seenStart <= 1'b1;
    end else if (carrierTick) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  // R7
  frame_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frameStart && seenStart) |-> (tickCnt == CNT_W'(FRAME_LEN)));

  // R8
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !carrierTick) |=> $stable(modOut));

  // R9
  start_sample_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |-> (modOut && $past(carrierTick) && $past(enable)));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!modOut && !frameStart));

endmodule

bind fskTagGen fskTagGenChecker #(
  .ID_BITS(ID_BITS), .BITS_PER_NIB(BITS_PER_NIB),
  .SHORT_PER(SHORT_PER), .SHORT_REPS(SHORT_REPS),
  .LONG_PER(LONG_PER), .LONG_REPS(LONG_REPS),
  .SOF_GROUPS(SOF_GROUPS), .SOF_KINDS(SOF_KINDS)
) chkInst (
  .clk(clk), .rst_n(rst_n), .enable(enable), .carrierTick(carrierTick),
  .modOut(modOut), .frameStart(frameStart)
);

// File: tb/fskTagGen_test.sv
`timescale 1ns/1ps
module fskTagGen_test;
  localparam int FRAME = 5232;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        carrierTick = 1'b0;
  logic [43:0] tagId = '0;
  logic        modOut, frameStart;

  int compared = 0;
  int mismatched = 0;
  int n = 0;
  int frameCount = 0;
  int tickNo = 0;
  bit midChange = 0;
  bit finished = 0;
  logic [43:0] activeId = '0;

  always #2 clk = ~clk;

  fskTagGen uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .carrierTick(carrierTick),
    .tagId(tagId), .modOut(modOut), .frameStart(frameStart)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %0b expected %0b (sample %0d, frame %0d)",
               tag, act, exp, n, frameCount);
    end
  endtask

  // Expected sample n of a frame for identifier id, with the rule it tests
  function automatic void expectSample(input logic [43:0] id, input int idx,
                                       output logic val, output string tag);
    int pos;
    pos = idx;
    val = 1'b0;
    tag = "R7";
    for (int g = 0; g < 107; g++) begin
      int kind, len, d, k, nb, j;
      string rg;
      if (g < 8) begin
        kind = (8'hB8 >> g) & 1;
        rg = "R4";
      end else begin
        d = g - 8; k = d % 9; nb = d / 9;
        if (k == 0) begin
          kind = 0; rg = "R6";
        end else begin
          j = (k - 1) / 2;
          kind = (((k - 1) % 2) == 0) ? int'(id[43 - (nb * 4 + j)])
                                       : int'(!id[43 - (nb * 4 + j)]);
          rg = "R5";
        end
      end
      len = (kind != 0) ? 50 : 48;
      if (pos < len) begin
        val = (kind != 0) ? ((pos % 10) < 3) : ((pos % 8) < 2);
        tag = {rg, (kind != 0) ? " R3" : " R2"};
        return;
      end
      pos -= len;
    end
  endfunction

  task automatic stepTick(input string over);
    logic ev;
    string tg;
    @(negedge clk) carrierTick = 1'b1;
    @(negedge clk) carrierTick = 1'b0;
    if (n == 0) begin
      activeId = tagId;
      midChange = 0;
    end
    expectSample(activeId, n, ev, tg);
    if (midChange) tg = "R10";
    if (over != "") tg = over;
    check(modOut, ev, tg);
    check(frameStart, n == 0, (n == 0 && frameCount > 0) ? "R7 R9" : "R9");
    if ((tickNo % 3) == 0) begin
      @(negedge clk);
      check(modOut, ev, "R8");
      check(frameStart, 1'b0, "R9");
    end
    tickNo++;
    n = (n + 1) % FRAME;
    if (n == 0) frameCount++;
  endtask

  task automatic runTicks(input int count);
    for (int i = 0; i < count; i++) stepTick("");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(modOut, 1'b0, "R1");
    check(frameStart, 1'b0, "R1");
    @(negedge clk) rst_n = 1'b1;

    // strobe while disabled is ignored
    @(negedge clk) carrierTick = 1'b1;
    @(negedge clk) carrierTick = 1'b0;
    check(modOut, 1'b0, "R11");
    check(frameStart, 1'b0, "R11");

    // frame of all zeros: every bit short-then-long
    tagId = 44'h0;
    enable = 1'b1;
    runTicks(FRAME);

    // frame of all ones, with the ID changed partway through it
    tagId = 44'hFFF_FFFF_FFFF;
    runTicks(1500);
    tagId = 44'hA5C_3F0F_1E2D;
    midChange = 1;
    runTicks(FRAME - 1500);

    // full frame of the mixed ID, then part of the next
    runTicks(FRAME + 2000);

    // disable in the middle of a frame
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    check(modOut, 1'b0, "R11");
    check(frameStart, 1'b0, "R11");
    @(negedge clk) carrierTick = 1'b1;
    @(negedge clk) carrierTick = 1'b0;
    check(modOut, 1'b0, "R11");
    check(frameStart, 1'b0, "R11");

    // restart from the marker with a new ID
    tagId = 44'h3C6_9B12_E4F7;
    enable = 1'b1;
    n = 0;
    frameCount = 0;
    midChange = 0;
    stepTick("R11");
    runTicks(FRAME + 20);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule